// File: doc/BRIEF.md
# Triggered Snapshot Capture Buffer

This block records a burst of samples into a 128-word, 16-bit on-chip buffer when a trigger pulse arrives. The samples come from one of four streams: two 12-bit inputs and two 16-bit outputs of a surrounding datapath. A single control register sets five things: which stream is recorded, how often a sample is stored (every one, two or four clocks), how long to wait after the trigger in 128-sample blocks, whether new triggers are refused, and whether each sample is cut down to its upper byte.

In byte mode one capture holds 256 bytes. The first 128 bytes fill the low byte lane of words 0 to 127 and the next 128 bytes fill the high lane of the same words. A done flag reports that the buffer holds a complete capture. A synchronous read port returns any word one clock after it is requested. Two instances with different delay settings give two views of the same event that are offset in time.

Top module: `snap_capture_buf`

## Requirements
- R1: Control register fields are: bits 1:0 source, bits 3:2 rate, bits 7:4 delay, bit 8 hold and bit 9 byte mode. A write on cfg_we is visible on cfg_rdata after that edge. The register resets to zero, and bits 15:10 always read zero.
- R2: Source code 0 records the 12-bit input B, code 1 the 12-bit input A, code 2 the 16-bit output A and code 3 the 16-bit output B. 12-bit samples are left-justified, with zeros in bits 3:0.
- R3: Rate codes 0, 1 and 3 store a sample every 1, 2 and 4 clocks. Code 2 behaves like code 3.
- R4: Let t be the edge that accepts a trigger, and let N = 128 × delay × step, where step is the store interval from R3. The first store samples the source at edge t+N+1, and later stores follow every step edges.
- R5: In word mode the k-th stored sample (k = 0..127) is written whole to word k.
- R6: In byte mode (bit 9 = 1) only bits 15:8 of the left-justified sample are kept. Byte k < 128 goes to bits 7:0 of word k, and byte k ≥ 128 goes to bits 15:8 of word k−128.
- R7: A trigger that arrives while the block is idle and the hold bit is set starts nothing. The done flag and the buffer contents stay unchanged.
- R8: done is 0 after reset. It becomes 1 from the edge of the final store and returns to 0 from the edge that accepts a new trigger.
- R9: A trigger during the delay or the storing phase is ignored. This includes a trigger that lands on the edge of the final store.
- R10: With rd_en high at an edge, rd_data shows the word at rd_addr after that edge. rd_data holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in_b | input | 12 | Input stream B, source code 0 |
| smp_in_a | input | 12 | Input stream A, source code 1 |
| smp_out_a | input | 16 | Output stream A, source code 2 |
| smp_out_b | input | 16 | Output stream B, source code 3 |
| trig | input | 1 | Capture trigger, sampled each edge |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write value |
| cfg_rdata | output | 16 | Control register contents |
| done | output | 1 | A complete capture is in the buffer |
| rd_en | input | 1 | Buffer read request |
| rd_addr | input | 7 | Buffer read word address |
| rd_data | output | 16 | Buffer read word, one cycle after request |

## Verification
Two functions can fall on the same edge: the final store of a capture and the arrival of a new trigger. If that trigger were accepted it would clear done and overwrite the buffer. The bench computes the edge index of the last store from the rate and delay, then drives the trigger so that it is sampled on exactly that edge. The trigger must be ignored: done must rise on that edge and stay high for several cycles, and words across the buffer must still match the samples of the original timing.

// File: rtl/snap_pkg.sv
package snap_pkg;

    localparam int CFG_W   = 10;
    localparam int DELAY_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CAP  = 2'd2
    } snap_state_e;

    // Field order follows the register bit layout, LSB last.
    typedef struct packed {
        logic               byte_mode;
        logic               hold;
        logic [DELAY_W-1:0] delay;
        logic [1:0]         rate;
        logic [1:0]         src;
    } snap_cfg_t;

    // Store interval in clocks; the unused code 2 maps onto the slowest rate.
    function automatic logic [2:0] step_of(input logic [1:0] rate);
        case (rate)
            2'd0:    step_of = 3'd1;
            2'd1:    step_of = 3'd2;
            default: step_of = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/snap_src_mux.sv
module snap_src_mux #(
    parameter int NARROW_W = 12,
    parameter int WIDE_W   = 16
) (
    input  logic [NARROW_W-1:0] in_b_n,
    input  logic [NARROW_W-1:0] in_a_n,
    input  logic [WIDE_W-1:0]   out_a_w,
    input  logic [WIDE_W-1:0]   out_b_w,
    input  logic [1:0]          sel,
    input  logic                byte_mode,
    output logic [WIDE_W-1:0]   wr_data
);
    localparam int PAD_W  = WIDE_W - NARROW_W;
    localparam int BYTE_W = WIDE_W / 2;

    logic [WIDE_W-1:0] sample;

    always_comb begin
        case (sel)
            2'd0:    sample = {in_b_n, {PAD_W{1'b0}}};
            2'd1:    sample = {in_a_n, {PAD_W{1'b0}}};
            2'd2:    sample = out_a_w;
            default: sample = out_b_w;
        endcase
        // In byte mode the upper byte is offered on both lanes; lane enables pick one.
        wr_data = byte_mode ? {2{sample[WIDE_W-1 -: BYTE_W]}} : sample;
    end

endmodule

// File: rtl/snap_seq.sv
module snap_seq
    import snap_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int BLK_LOG2 = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [1:0]        act_src,
    output logic              act_byte,
    output logic [1:0]        wr_lane_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W  = ADDR_W + 1;
    localparam int WAIT_W = BLK_LOG2 + DELAY_W + 2;

    typedef struct packed {
        snap_state_e       st;
        snap_cfg_t         cfg;
        snap_cfg_t         act;
        logic [WAIT_W-1:0] wcnt;
        logic [1:0]        phase;
        logic [IDX_W-1:0]  idx;
        logic              done;
    } seq_t;

    seq_t s_q, s_d;

    logic [2:0]        act_step, cfg_step;
    logic [WAIT_W-1:0] dly_cycles;
    logic              store, last;

    always_comb begin
        s_d        = s_q;
        act_step   = step_of(s_q.act.rate);
        cfg_step   = step_of(s_q.cfg.rate);
        dly_cycles = (WAIT_W'(s_q.cfg.delay) * WAIT_W'(cfg_step)) << BLK_LOG2;
        store      = (s_q.st == ST_CAP) && (s_q.phase == 2'd0);
        last       = s_q.act.byte_mode ? (&s_q.idx) : (&s_q.idx[ADDR_W-1:0]);

        if (cfg_we) s_d.cfg = snap_cfg_t'(cfg_wdata);

        case (s_q.st)
            ST_IDLE: begin
                if (trig && !s_q.cfg.hold) begin
                    s_d.act   = s_q.cfg;
                    s_d.done  = 1'b0;
                    s_d.phase = 2'd0;
                    s_d.idx   = '0;
                    if (dly_cycles == '0) begin
                        s_d.st = ST_CAP;
                    end else begin
                        s_d.st   = ST_WAIT;
                        s_d.wcnt = dly_cycles - WAIT_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (s_q.wcnt == '0) s_d.st = ST_CAP;
                else                s_d.wcnt = s_q.wcnt - WAIT_W'(1);
            end
            ST_CAP: begin
                s_d.phase = (s_q.phase == 2'(act_step - 3'd1)) ? 2'd0 : s_q.phase + 2'd1;
                if (store) begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                    if (last) begin
                        s_d.st    = ST_IDLE;
                        s_d.done  = 1'b1;
                        s_d.phase = 2'd0;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cfg: '0, act: '0, wcnt: '0, phase: 2'd0, idx: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_q      = s_q.cfg;
    assign act_src    = s_q.act.src;
    assign act_byte   = s_q.act.byte_mode;
    assign wr_addr    = s_q.idx[ADDR_W-1:0];
    assign wr_lane_en = !store ? 2'b00 :
                        !s_q.act.byte_mode ? 2'b11 :
                        (s_q.idx[ADDR_W] ? 2'b10 : 2'b01);
    assign busy       = (s_q.st != ST_IDLE);
    assign done       = s_q.done;

endmodule

// File: rtl/snap_mem.sv
module snap_mem #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we[l]) mem_q[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= mem_q[rd_addr];
        end

        assign rd_data[l*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/snap_capture_buf.sv
module snap_capture_buf
    import snap_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int NARROW_W = 12,
    parameter int WIDE_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NARROW_W-1:0] smp_in_b,
    input  logic [NARROW_W-1:0] smp_in_a,
    input  logic [WIDE_W-1:0]   smp_out_a,
    input  logic [WIDE_W-1:0]   smp_out_b,
    input  logic                trig,
    input  logic                cfg_we,
    input  logic [WIDE_W-1:0]   cfg_wdata,
    output logic [WIDE_W-1:0]   cfg_rdata,
    output logic                done,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WIDE_W-1:0]   rd_data
);
    // A delay block spans one buffer's worth of samples.
    localparam int BLK_LOG2 = ADDR_W;

    logic [CFG_W-1:0]  cfg_q;
    logic [1:0]        act_src;
    logic              act_byte;
    logic [1:0]        wr_lane_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WIDE_W-1:0] wr_data;
    logic              busy;

    snap_seq #(
        .ADDR_W   (ADDR_W),
        .BLK_LOG2 (BLK_LOG2)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata[CFG_W-1:0]),
        .cfg_q      (cfg_q),
        .act_src    (act_src),
        .act_byte   (act_byte),
        .wr_lane_en (wr_lane_en),
        .wr_addr    (wr_addr),
        .busy       (busy),
        .done       (done)
    );

    snap_src_mux #(
        .NARROW_W (NARROW_W),
        .WIDE_W   (WIDE_W)
    ) u_mux (
        .in_b_n    (smp_in_b),
        .in_a_n    (smp_in_a),
        .out_a_w   (smp_out_a),
        .out_b_w   (smp_out_b),
        .sel       (act_src),
        .byte_mode (act_byte),
        .wr_data   (wr_data)
    );

    snap_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (WIDE_W),
        .LANES  (2)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_lane_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign cfg_rdata = WIDE_W'(cfg_q);

endmodule

// File: rtl/snap_capture_chk.sv
module snap_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trig,
    input logic        cfg_we,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic        done,
    input logic        busy,
    input logic [1:0]  wr_lane_en
);

    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == {6'b0, $past(cfg_wdata[9:0])}); // R1

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig && !cfg_rdata[8]) |=> (busy && !done)); // R8

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig && cfg_rdata[8]) |=> (!busy && $stable(done))); // R7

    AST_DONE_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_lane_en != 2'b00)); // R8

    AST_RETRIG_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig && wr_lane_en == 2'b00) |=> busy); // R9

    AST_NO_STORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lane_en != 2'b00) |-> !done); // R5

endmodule

bind snap_capture_buf snap_capture_chk chk_i (.*);

// File: tb/snap_capture_buf_tb_top.sv
`timescale 1ns/1ps
module snap_capture_buf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] smp_in_b = '0, smp_in_a = '0;
    logic [15:0] smp_out_a = '0, smp_out_b = '0;
    logic        trig = 1'b0, cfg_we = 1'b0, rd_en = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] cfg_rdata, rd_data;
    logic        done;

    int n_chk = 0, n_err = 0, ecnt = 0, wd = 0;
    int e_first, e_last, stp, nent, sel;
    logic bm;

    always #4 clk = ~clk;

    snap_capture_buf dut_i (
        .clk(clk), .rst_n(rst_n), .smp_in_b(smp_in_b), .smp_in_a(smp_in_a),
        .smp_out_a(smp_out_a), .smp_out_b(smp_out_b), .trig(trig),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .done(done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Config rows: source/rate/delay/byte-mode mixes (R2, R3, R4).
    localparam logic [15:0] CFG_TAB [7] = '{
        16'h0000, 16'h0015, 16'h000E, 16'h002B, 16'h0202, 16'h0235, 16'h0218
    };

    function automatic logic [11:0] raw_b(input int e); return 12'(e * 3 + 5);          endfunction
    function automatic logic [11:0] raw_a(input int e); return 12'(e * 5 + 1);          endfunction
    function automatic logic [15:0] raw_oa(input int e); return 16'(e * 7 + 16'h1234);  endfunction
    function automatic logic [15:0] raw_ob(input int e); return 16'(e * 13) ^ 16'hA5C3; endfunction

    function automatic logic [15:0] src_at(input int s, input int e);
        case (s)
            0:       return {raw_b(e), 4'h0};
            1:       return {raw_a(e), 4'h0};
            2:       return raw_oa(e);
            default: return raw_ob(e);
        endcase
    endfunction

    function automatic logic [15:0] exp_word(input int a);
        logic [15:0] lo_s, hi_s;
        if (!bm) return src_at(sel, e_first + a * stp);
        lo_s = src_at(sel, e_first + a * stp);
        hi_s = src_at(sel, e_first + (a + 128) * stp);
        return {hi_s[15:8], lo_s[15:8]};
    endfunction

    always @(posedge clk) ecnt <= ecnt + 1;

    always @(negedge clk) begin
        smp_in_b  <= raw_b(ecnt);
        smp_in_a  <= raw_a(ecnt);
        smp_out_a <= raw_oa(ecnt);
        smp_out_b <= raw_ob(ecnt);
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] c);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = c;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = 7'(a);
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic start_cap(input logic [15:0] c);
        int r, dly;
        sel = c[1:0]; r = c[3:2]; dly = c[7:4]; bm = c[9];
        stp = (r == 0) ? 1 : (r == 1) ? 2 : 4;
        nent = bm ? 256 : 128;
        write_cfg(c);
        trig = 1'b1;
        e_first = ecnt + 128 * dly * stp + 1;
        @(negedge clk); trig = 1'b0;
        e_last = e_first + (nent - 1) * stp;
        check("R8 done cleared on start", done, 0);
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 20000) begin @(negedge clk); guard++; end
        check("R4 final store edge", ecnt, e_last + 1);
    endtask

    task automatic check_words(input string req);
        int addrs [4] = '{0, 1, 64, 127};
        logic [15:0] d;
        foreach (addrs[j]) begin
            rd(addrs[j], d);
            check(req, d, exp_word(addrs[j]));
        end
    endtask

    initial begin
        logic [15:0] d, keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 done after reset", done, 0);
        check("R1 cfg after reset", cfg_rdata, 16'h0000);
        write_cfg(16'hFFFF);
        check("R1 unused bits read zero", cfg_rdata, 16'h03FF);

        for (int i = 0; i < 7; i++) begin
            start_cap(CFG_TAB[i]);
            wait_done();
            check_words(bm ? "R6 byte packing R2 R3" : "R5 word order R2 R3");
        end

        // R7: hold refuses a trigger; done and buffer untouched.
        keep = exp_word(0);
        write_cfg(16'h0102);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        repeat (300) @(negedge clk);
        check("R7 hold keeps done", done, 1);
        rd(0, d);
        check("R7 hold keeps data", d, keep);

        // R10: data appears one cycle after request and holds while rd_en low.
        @(negedge clk); rd_en = 1'b1; rd_addr = 7'd0;
        @(negedge clk); rd_en = 1'b0; rd_addr = 7'd1;
        check("R10 read latency", rd_data, keep);
        @(negedge clk);
        check("R10 read hold", rd_data, keep);

        // R9: trigger mid-capture and on the final store edge is ignored.
        start_cap(16'h000E);
        repeat (50) @(negedge clk);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        while (ecnt < e_last) @(negedge clk);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        check("R9 done on last store edge", done, 1);
        check("R9 last store edge index", ecnt, e_last + 1);
        repeat (3) @(negedge clk);
        check("R9 coincident trigger ignored", done, 1);
        check_words("R9 data keeps original timing");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule